// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a synchronous client and an asynchronous static memory that has one active-low and one active-high chip enable, an active-low write strobe, an active-low output enable and one active-low select per byte lane. The client offers one word at a time on a valid/ready channel: a read or write flag, an address, write data and a lane mask. The block turns each request into a sequence of clocked phases. The memory pins are decoded from the phase, so they change only on clock edges. Read data returns with a one-cycle strobe.

Each phase length comes from a memory timing figure in nanoseconds and the clock period. The figures are parameters of the block. Each figure becomes a cycle count by rounding up, and the phase takes the largest count among the figures it must cover. A read keeps output enable low long enough for both the address access time and the output-enable access time, then holds the bus idle for the memory's output turn-off time. A write keeps write enable low long enough for the pulse width, the data setup time and the lane-select setup time. Write enable then rises while the chip enables stay active, so the write always ends on that edge.

Top module: `sram_seq_top`

## Requirements
- R1: After reset and whenever the block is idle, reqReady is 1, memCe1N is 1, memCe2 is 0, memWeN is 1, memOeN is 1, memDqOe is 0 and every memLaneN bit is 1.
- R2: A timing figure of t ns becomes ceil(t / CLK_NS) cycles, and a nonzero figure always gives at least one cycle. The phase lengths are: read = max of the read-cycle, address-access and output-enable counts; turnaround = the output turn-off count, at least 1; write pulse = max of the pulse-width, data-setup and lane-setup counts; write hold = write-cycle count minus write pulse, at least 1.
- R3: A read holds memOeN at 0 with both chip enables active for exactly the read length. rdValid is 1 for exactly one cycle, the cycle after the last read cycle. rdData then holds memDqIn as sampled in that last read cycle.
- R4: After a read, both chip enables are inactive and memOeN is 1 for exactly the turnaround length before reqReady returns to 1. memDqOe stays 0 throughout.
- R5: A write holds memWeN at 0 for exactly the write pulse length. memDqOe is 1 and memDqOut equals the request's write data in every one of those cycles.
- R6: memWeN rises while memCe1N is 0, memCe2 is 1 and memDqOe is 1. The chip enables and the data drive then stay on for exactly the write hold length before reqReady returns to 1.
- R7: memAddr equals the accepted address in every cycle of the access, and it does not change while memWeN is 0.
- R8: reqReady falls in the cycle after a request is accepted and stays 0 until the last phase ends. A request presented while reqReady is 0 is not accepted and has no effect on the memory.
- R9: Bit i of reqLaneEn selects data bits [8i+7:8i]. During an access, memLaneN[i] equals the inverse of reqLaneEn[i]. Outside an access, every memLaneN bit is 1.
- R10: memDqOe is never 1 in a cycle where memOeN is 0.
- R11: rdValid never stays 1 for two cycles in a row and is never 1 as a result of a write.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and able to accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqLaneEn | input | DATA_W/8 | Byte lanes to access, active high |
| rdValid | output | 1 | One-cycle strobe marking rdData valid |
| rdData | output | DATA_W | Captured read word |
| memCe1N | output | 1 | Memory chip enable, active low |
| memCe2 | output | 1 | Memory chip enable, active high |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memLaneN | output | DATA_W/8 | Memory byte-lane selects, active low |
| memAddr | output | ADDR_W | Memory address |
| memDqOut | output | DATA_W | Data driven toward the memory |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | DATA_W | Data returned by the memory |

## Verification
The bench builds the block with a 5 ns clock and timing figures that are not all multiples of the period: 57 ns address access, 32 ns write pulse and 22 ns turnaround. Rounding up then gives a 12-cycle read, 5-cycle turnaround, 7-cycle write pulse and 4-cycle write hold, so a truncating conversion, or a phase that picks the wrong figure, shows up as a wrong cycle count. A byte-lane memory model in the bench lets partial-lane writes and reads with some lanes disabled be checked end to end. A request pulsed during a busy read shows whether anything is accepted while reqReady is 0.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_HOLD
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // latch the accepted request
    logic select;   // chip enables active
    logic outEn;    // output enable active
    logic wrEn;     // write enable active
    logic drive;    // drive the data bus
    logic capture;  // sample the data bus into rdData
  } seqStrobe_t;

  // Ceiling conversion from ns to cycles; nonzero time gives at least one cycle
  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned clkNs);
    if (ns == 0) return 0;
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned RD_LEN = 11,
  parameter int unsigned TA_LEN = 5,
  parameter int unsigned WP_LEN = 6,
  parameter int unsigned WH_LEN = 5,
  parameter int unsigned CNT_W  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic       isWrite,
  output seqStrobe_t strobe,
  output logic       idle
);

  localparam logic [CNT_W-1:0] RD_M1 = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] TA_M1 = CNT_W'(TA_LEN - 1);
  localparam logic [CNT_W-1:0] WP_M1 = CNT_W'(WP_LEN - 1);
  localparam logic [CNT_W-1:0] WH_M1 = CNT_W'(WH_LEN - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             lastCycle;

  assign lastCycle = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= isWrite ? ST_WRITE : ST_READ;
            cnt   <= isWrite ? WP_M1 : RD_M1;
          end
        end
        ST_READ: begin
          if (lastCycle) begin
            state <= ST_TURN;
            cnt   <= TA_M1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TURN: begin
          if (lastCycle) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_WRITE: begin
          if (lastCycle) begin
            state <= ST_HOLD;
            cnt   <= WH_M1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (lastCycle) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    idle           = (state == ST_IDLE);
    strobe.load    = idle && accept;
    strobe.select  = (state == ST_READ) || (state == ST_WRITE) || (state == ST_HOLD);
    strobe.outEn   = (state == ST_READ);
    strobe.wrEn    = (state == ST_WRITE);
    strobe.drive   = (state == ST_WRITE) || (state == ST_HOLD);
    strobe.capture = (state == ST_READ) && lastCycle;
  end

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLaneEn,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  laneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '0;
      laneQ   <= '0;
      rdValid <= 1'b0;
    end else begin
      if (strobe.load) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        laneQ <= reqLaneEn;
      end
      rdValid <= strobe.capture;
    end
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               rdData[8*gi +: 8] <= '0;
      else if (strobe.capture) rdData[8*gi +: 8] <= memDqIn[8*gi +: 8];
    end
    assign memLaneN[gi] = ~(strobe.select & laneQ[gi]);
  end

  assign memCe1N  = ~strobe.select;
  assign memCe2   = strobe.select;
  assign memWeN   = ~strobe.wrEn;
  assign memOeN   = ~strobe.outEn;
  assign memDqOe  = strobe.drive;
  assign memDqOut = dataQ;
  assign memAddr  = addrQ;

endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top
  import sram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned T_RC_NS   = 55,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_OE_NS   = 30,
  parameter int unsigned T_OHZ_NS  = 25,
  parameter int unsigned T_WC_NS   = 55,
  parameter int unsigned T_WP_NS   = 30,
  parameter int unsigned T_DW_NS   = 25,
  parameter int unsigned T_BW_NS   = 25
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  output logic                  reqReady,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqLaneEn,
  output logic                  rdValid,
  output logic [DATA_W-1:0]     rdData,
  output logic                  memCe1N,
  output logic                  memCe2,
  output logic                  memWeN,
  output logic                  memOeN,
  output logic [DATA_W/8-1:0]   memLaneN,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memDqOut,
  output logic                  memDqOe,
  input  logic [DATA_W-1:0]     memDqIn
);

  localparam int unsigned LANES  = DATA_W / 8;
  // R2: phase lengths from rounded-up timing figures
  localparam int unsigned RC_CY  = nsToCycles(T_RC_NS, CLK_NS);
  localparam int unsigned AA_CY  = nsToCycles(T_AA_NS, CLK_NS);
  localparam int unsigned OE_CY  = nsToCycles(T_OE_NS, CLK_NS);
  localparam int unsigned OHZ_CY = nsToCycles(T_OHZ_NS, CLK_NS);
  localparam int unsigned WC_CY  = nsToCycles(T_WC_NS, CLK_NS);
  localparam int unsigned WP_CY  = nsToCycles(T_WP_NS, CLK_NS);
  localparam int unsigned DW_CY  = nsToCycles(T_DW_NS, CLK_NS);
  localparam int unsigned BW_CY  = nsToCycles(T_BW_NS, CLK_NS);

  localparam int unsigned RD_LEN = maxOf(1, maxOf(RC_CY, maxOf(AA_CY, OE_CY)));
  localparam int unsigned TA_LEN = maxOf(1, OHZ_CY);
  localparam int unsigned WP_LEN = maxOf(1, maxOf(WP_CY, maxOf(DW_CY, BW_CY)));
  localparam int unsigned WH_LEN = maxOf(1, (WC_CY > WP_LEN) ? (WC_CY - WP_LEN) : 0);
  localparam int unsigned MAX_LEN = maxOf(maxOf(RD_LEN, TA_LEN), maxOf(WP_LEN, WH_LEN));
  localparam int unsigned CNT_W  = maxOf(1, $clog2(MAX_LEN + 1));

  seqStrobe_t strobe;
  logic       idle;
  logic       accept;

  assign reqReady = idle;
  assign accept   = reqValid && idle;

  sram_seq_ctrl #(
    .RD_LEN(RD_LEN),
    .TA_LEN(TA_LEN),
    .WP_LEN(WP_LEN),
    .WH_LEN(WH_LEN),
    .CNT_W (CNT_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .accept (accept),
    .isWrite(reqWrite),
    .strobe (strobe),
    .idle   (idle)
  );

  sram_seq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqLaneEn(reqLaneEn),
    .memDqIn  (memDqIn),
    .memCe1N  (memCe1N),
    .memCe2   (memCe2),
    .memWeN   (memWeN),
    .memOeN   (memOeN),
    .memLaneN (memLaneN),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memDqOe  (memDqOe),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rdValid,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN,
  input logic [LANES-1:0]  memLaneN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDqOe
);

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCe1N && !memCe2 && memWeN && memOeN && !memDqOe));

  // R9
  idle_lanes_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (&memLaneN));

  // R10
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memDqOe && !memOeN));

  // R5
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDqOe);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && !$past(memWeN)) |-> $stable(memAddr));

  // R6
  we_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCe1N && memCe2 && memDqOe));

  // R11
  rdvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind sram_seq_top sram_seq_chk #(
  .ADDR_W(ADDR_W),
  .LANES (DATA_W / 8)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .rdValid (rdValid),
  .memCe1N (memCe1N),
  .memCe2  (memCe2),
  .memWeN  (memWeN),
  .memOeN  (memOeN),
  .memLaneN(memLaneN),
  .memAddr (memAddr),
  .memDqOe (memDqOe)
);

// File: tb/tb_sram_seq_top.sv
module tb_sram_seq_top;

  localparam int AW = 18;
  localparam int DW = 16;
  localparam int LN = 2;
  localparam int CLK_NS = 5;
  localparam int AA_NS = 57, RC_NS = 55, OE_NS = 30, OHZ_NS = 22;
  localparam int WC_NS = 55, WP_NS = 32, DW_NS = 25, BW_NS = 25;

  function automatic int ceilCy(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R2: expected phase lengths, worked out independently
  localparam int EXP_RD = mx(ceilCy(RC_NS), mx(ceilCy(AA_NS), ceilCy(OE_NS))); // 12
  localparam int EXP_TA = mx(1, ceilCy(OHZ_NS));                              // 5
  localparam int EXP_WP = mx(ceilCy(WP_NS), mx(ceilCy(DW_NS), ceilCy(BW_NS)));  // 7
  localparam int EXP_WH = mx(1, ceilCy(WC_NS) - EXP_WP);                      // 4

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [LN-1:0] reqLaneEn = '0;
  logic reqReady, rdValid, memCe1N, memCe2, memWeN, memOeN, memDqOe;
  logic [DW-1:0] rdData, memDqOut, memDqIn;
  logic [LN-1:0] memLaneN;
  logic [AW-1:0] memAddr;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #(CLK_NS * 500ps) clk = ~clk;

  sram_seq_top #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS),
    .T_RC_NS(RC_NS), .T_AA_NS(AA_NS), .T_OE_NS(OE_NS), .T_OHZ_NS(OHZ_NS),
    .T_WC_NS(WC_NS), .T_WP_NS(WP_NS), .T_DW_NS(DW_NS), .T_BW_NS(BW_NS)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLaneEn(reqLaneEn),
    .rdValid(rdValid), .rdData(rdData), .memCe1N(memCe1N), .memCe2(memCe2),
    .memWeN(memWeN), .memOeN(memOeN), .memLaneN(memLaneN), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Byte-lane memory model, 16 words indexed by address bits [3:0]
  logic [DW-1:0] mem [16];
  initial for (int i = 0; i < 16; i++) mem[i] = '0;

  always @(posedge memWeN) begin
    if (memCe1N === 1'b0 && memCe2 === 1'b1) begin
      for (int i = 0; i < LN; i++)
        if (!memLaneN[i]) mem[memAddr[3:0]][8*i +: 8] = memDqOut[8*i +: 8];
    end
  end

  always_comb begin
    for (int i = 0; i < LN; i++)
      memDqIn[8*i +: 8] = (memCe1N === 1'b0 && memCe2 === 1'b1 && memOeN === 1'b0 && !memLaneN[i])
                          ? mem[memAddr[3:0]][8*i +: 8] : 8'hEE;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Stimulus table: {write, addr, wdata, lanes, expected read data}
  localparam int NV = 10;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1, 18'h00003, 16'h1234, 2'b11, 16'h0000},
    {1'b0, 18'h00003, 16'h0000, 2'b11, 16'h1234},
    {1'b1, 18'h00003, 16'hABCD, 2'b01, 16'h0000},
    {1'b0, 18'h00003, 16'h0000, 2'b11, 16'h12CD},
    {1'b1, 18'h00007, 16'h5A5A, 2'b10, 16'h0000},
    {1'b0, 18'h00007, 16'h0000, 2'b10, 16'h5AEE},
    {1'b0, 18'h00007, 16'h0000, 2'b01, 16'hEE00},
    {1'b1, 18'h3FFFF, 16'hFFFF, 2'b11, 16'h0000},
    {1'b0, 18'h3FFFF, 16'h0000, 2'b11, 16'hFFFF},
    {1'b0, 18'h00010, 16'h0000, 2'b11, 16'h0000}
  };

  // Issue one request at a negedge with reqReady high; observe every cycle until idle.
  // injectAt > 0 pulses a stray write request (addr 5) in that busy cycle.
  task automatic runOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [LN-1:0] ln, input logic [DW-1:0] expRd, input int injectAt);
    int oeLow = 0, weLow = 0, hold = 0, tail = 0, busy = 0, rv = 0;
    bit addrBad = 0, driveBad = 0, laneBad = 0, turnBad = 0, contBad = 0;
    logic [DW-1:0] got = '0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqLaneEn = ln;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check(reqReady === 1'b0, "R8", "ready after accept", int'(reqReady), 0);
    while (reqReady !== 1'b1 && busy < 100) begin
      busy++;
      if (injectAt != 0 && busy == injectAt) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 18'h00005; reqWdata = 16'hBEEF; reqLaneEn = 2'b11;
      end else if (injectAt != 0 && busy == injectAt + 1) begin
        reqValid = 1'b0;
      end
      if (memDqOe && !memOeN) contBad = 1;
      if (!memCe1N) begin
        if (memAddr !== a) addrBad = 1;
        if (memLaneN !== ~ln) laneBad = 1;
      end else if (memLaneN !== '1) laneBad = 1;
      if (!memOeN) oeLow++;
      if (!memWeN) begin
        weLow++;
        if (memDqOe !== 1'b1 || memDqOut !== d) driveBad = 1;
      end else if (wr && weLow > 0 && !memCe1N && memCe2) begin
        hold++;
        if (memDqOe !== 1'b1) driveBad = 1;
      end
      if (!wr && oeLow > 0 && memOeN) begin
        tail++;
        if (!memCe1N || memCe2 || memDqOe) turnBad = 1;
      end
      if (rdValid) begin rv++; got = rdData; end
      @(negedge clk);
    end
    check(!contBad, "R10", "drive while output enabled", int'(contBad), 0);
    check(!addrBad, "R7", "address held during access", int'(addrBad), 0);
    check(!laneBad, "R9", "lane selects", int'(laneBad), 0);
    if (wr) begin
      check(busy == EXP_WP + EXP_WH, "R8", "write busy cycles", busy, EXP_WP + EXP_WH);
      check(weLow == EXP_WP, "R5", "write pulse cycles", weLow, EXP_WP);
      check(hold == EXP_WH, "R6", "write hold cycles", hold, EXP_WH);
      check(!driveBad, "R5", "write data driven", int'(driveBad), 0);
      check(oeLow == 0, "R5", "output enable during write", oeLow, 0);
      check(rv == 0, "R11", "rdValid on write", rv, 0);
    end else begin
      check(busy == EXP_RD + EXP_TA, "R8", "read busy cycles", busy, EXP_RD + EXP_TA);
      check(oeLow == EXP_RD, "R3", "read phase cycles", oeLow, EXP_RD);
      check(tail == EXP_TA && !turnBad, "R4", "turnaround cycles", tail, EXP_TA);
      check(weLow == 0, "R3", "write enable during read", weLow, 0);
      check(rv == 1, "R11", "rdValid pulse count", rv, 1);
      check(got === expRd, "R3", "read data", int'(got), int'(expRd));
    end
    check(rdValid === 1'b0 && memCe1N === 1'b1 && memWeN === 1'b1 && memOeN === 1'b1,
          "R1", "idle pins after op", int'({rdValid, memCe1N, memWeN, memOeN}), 4'b0111);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check(reqReady === 1'b1 && memCe1N === 1'b1 && memCe2 === 1'b0 && memWeN === 1'b1 &&
          memOeN === 1'b1 && memDqOe === 1'b0 && memLaneN === 2'b11 && rdValid === 1'b0,
          "R1", "pins in reset", int'({reqReady, memCe1N, memCe2, memWeN, memOeN, memDqOe}), 6'b110110);
    rstN = 1'b1;
    @(negedge clk); @(negedge clk);
    check(reqReady === 1'b1 && memCe1N === 1'b1 && memDqOe === 1'b0, "R1", "idle after reset",
          int'({reqReady, memCe1N, memDqOe}), 3'b110);

    for (int v = 0; v < NV; v++) begin
      runOp(VEC[v][52], VEC[v][51:34], VEC[v][33:18], VEC[v][17:16], VEC[v][15:0], 0);
      @(negedge clk);
    end

    // R8: stray request while busy must be ignored
    runOp(1'b0, 18'h00003, 16'h0000, 2'b11, 16'h12CD, 3);
    repeat (3) begin
      check(memWeN === 1'b1 && memCe1N === 1'b1 && reqReady === 1'b1, "R8",
            "no op started by stray request", int'({memWeN, memCe1N, reqReady}), 3'b111);
      @(negedge clk);
    end
    runOp(1'b0, 18'h00005, 16'h0000, 2'b11, 16'h0000, 0);

    // R9: write with no lanes leaves the word untouched
    runOp(1'b1, 18'h00003, 16'h0000, 2'b00, 16'h0000, 0);
    @(negedge clk);
    runOp(1'b0, 18'h00003, 16'h0000, 2'b11, 16'h12CD, 0);

    // Back-to-back writes then read
    runOp(1'b1, 18'h00009, 16'h00C3, 2'b01, 16'h0000, 0);
    runOp(1'b1, 18'h00009, 16'h3C00, 2'b10, 16'h0000, 0);
    runOp(1'b0, 18'h00009, 16'h0000, 2'b11, 16'h3CC3, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule